// File: doc/BRIEF.md
# Indirect Pointer Address Unit

This block turns the operand field of an 8-bit core's file-register access into a 12-bit data-memory address and routes the byte moving between the core and a 4096-byte data RAM. Direct accesses build the address from a 4-bit bank number, an access-bank flag and the 8-bit operand. The block also keeps three 12-bit pointers. Each pointer appears to software as two byte registers, a low byte and a high byte, in the top special-register region.

Three further addresses in that region have no storage of their own. Software uses them as indirect operands. A read or write that names indirect operand n is redirected to the location held in pointer n. In that case the bank number and the access flag play no part in the final address. This lets code walk the whole 000h–FFFh space linearly without changing banks. If the target of an indirect access is itself a pointer register, that register is accessed. If the target is an indirect operand, the access is suppressed.

The RAM is expected to answer a read in the same cycle, and it takes a write on the next rising clock edge. Pointer registers load on the rising edge after the write strobe. The core performs read-modify-write as a read cycle followed by a write cycle.

Top module: `ptr_addr_unit`

## Requirements
- R1: After synchronous reset, all three pointers hold 000h, so every pointer byte register reads 00h.
- R2: The low byte of pointer n is at address FD0h+2n and the high byte is at FD1h+2n. Each byte can be written and read back separately, and such accesses never assert the RAM write enable.
- R3: A pointer's high byte keeps only its bits [3:0]. A read returns zeros in bits [7:4], and data written to bits [7:4] is discarded.
- R4: With the access flag clear, the RAM address is {bank[3:0], operand[7:0]}.
- R5: With the access flag set, operands 00h–7Fh address 000h–07Fh, and operands 80h–FFh address F80h–FFFh.
- R6: Indirect operand n sits at address FD8h+n. A read of it returns the RAM byte at the address held in pointer n, and a write to it stores the core write data there. For example, with pointer 1 holding ECCh, a read and then a write through FD9h both use RAM location ECCh.
- R7: For an indirect access, the RAM address does not depend on the bank number or on which direct path (access flag set, or bank Fh with the flag clear) reached the indirect operand.
- R8: If pointer n holds an indirect-operand address (FD8h–FDAh), a read through operand n returns 00h and a write through it leaves RAM and the pointers unchanged.
- R9: A pointer write takes effect from the next cycle. A cycle without a write strobe leaves all pointers unchanged.
- R10: The RAM write enable is high only in a write cycle whose final target is a RAM location, and the RAM write data then equals the core write data.
- R11: The core read data is 00h whenever the read strobe is low.
- R12: If pointer n holds the address of a pointer byte register, an indirect access through operand n reads or writes that pointer byte instead of RAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| core_rd | input | 1 | Core read strobe |
| core_wr | input | 1 | Core write strobe |
| core_op | input | 8 | Operand address field |
| core_acc | input | 1 | Access-bank flag |
| core_bsr | input | 4 | Bank number for direct accesses |
| core_wdata | input | 8 | Core write data |
| core_rdata | output | 8 | Core read data |
| ram_addr | output | 12 | Data RAM address |
| ram_we | output | 1 | Data RAM write enable |
| ram_wdata | output | 8 | Data RAM write data |
| ram_rdata | input | 8 | Data RAM read data, valid in the same cycle |

## Verification
Direct accesses are tried with the access flag clear across all banks, and with it set on both sides of operand 80h. This separates bank concatenation from the split access-bank mapping. Indirect accesses are tried through each operand with pointers aimed at ordinary RAM, at pointer bytes and at the indirect operands themselves. These three cases tell plain redirection apart from pointer aliasing and from suppressed recursion. Repeating the same indirect access under every bank number shows that the bank has no effect. Random mixes of strobes, flags and operands, weighted toward the special-register region, test the pointer write-then-use timing against a bench model of the pointers.

// File: rtl/ptr_addr_pkg.sv
package ptr_addr_pkg;

    // Final destination of one core access
    typedef enum logic [1:0] {
        TGT_RAM  = 2'd0,
        TGT_PTR  = 2'd1,
        TGT_NULL = 2'd2
    } tgt_e;

endpackage

// File: rtl/ptr_direct_addr.sv
module ptr_direct_addr #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0]        op,
    input  logic                     acc,
    input  logic [ADDR_W-DATA_W-1:0] bsr,
    output logic [ADDR_W-1:0]        addr
);
    localparam int BANK_W = ADDR_W - DATA_W;

    always_comb begin
        if (!acc) begin
            addr = {bsr, op};
        end else if (op[DATA_W-1]) begin
            addr = {{BANK_W{1'b1}}, op};
        end else begin
            addr = {{BANK_W{1'b0}}, op};
        end
    end
endmodule

// File: rtl/ptr_sfr_decode.sv
module ptr_sfr_decode #(
    parameter int                 ADDR_W    = 12,
    parameter int                 NUM_PTR   = 3,
    parameter int                 IDX_W     = 2,
    parameter logic [ADDR_W-1:0]  PTR_BASE  = 12'hFD0,
    parameter logic [ADDR_W-1:0]  VIRT_BASE = 12'hFD8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              is_ptr,
    output logic [IDX_W-1:0]  ptr_idx,
    output logic              ptr_hi,
    output logic              is_virt,
    output logic [IDX_W-1:0]  virt_idx
);
    logic [NUM_PTR-1:0] hit_lo;
    logic [NUM_PTR-1:0] hit_hi;
    logic [NUM_PTR-1:0] hit_v;

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_hit
        assign hit_lo[g] = (addr == PTR_BASE + ADDR_W'(2 * g));
        assign hit_hi[g] = (addr == PTR_BASE + ADDR_W'(2 * g + 1));
        assign hit_v[g]  = (addr == VIRT_BASE + ADDR_W'(g));
    end

    always_comb begin
        ptr_idx  = '0;
        ptr_hi   = 1'b0;
        virt_idx = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (hit_lo[i] || hit_hi[i]) begin
                ptr_idx = IDX_W'(i);
                ptr_hi  = hit_hi[i];
            end
            if (hit_v[i]) begin
                virt_idx = IDX_W'(i);
            end
        end
        is_ptr  = |{hit_lo, hit_hi};
        is_virt = |hit_v;
    end
endmodule

// File: rtl/ptr_file.sv
module ptr_file #(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 8,
    parameter int NUM_PTR = 3,
    parameter int IDX_W   = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic                      wr_hi,
    input  logic [DATA_W-1:0]         wr_data,
    output logic [NUM_PTR*ADDR_W-1:0] ptr_flat
);
    localparam int BANK_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [NUM_PTR-1:0][ADDR_W-1:0] ptr;
    } state_t;

    state_t state_d;
    state_t state_q;

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (wr_en && (wr_idx == IDX_W'(i))) begin
                if (wr_hi) begin
                    state_d.ptr[i][ADDR_W-1:DATA_W] = wr_data[BANK_W-1:0];
                end else begin
                    state_d.ptr[i][DATA_W-1:0] = wr_data;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ptr_flat = state_q.ptr;
endmodule

// File: rtl/ptr_addr_unit.sv
module ptr_addr_unit
    import ptr_addr_pkg::*;
#(
    parameter int                 ADDR_W    = 12,
    parameter int                 DATA_W    = 8,
    parameter int                 NUM_PTR   = 3,
    parameter logic [ADDR_W-1:0]  PTR_BASE  = 12'hFD0,
    parameter logic [ADDR_W-1:0]  VIRT_BASE = 12'hFD8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       core_rd,
    input  logic                       core_wr,
    input  logic [DATA_W-1:0]          core_op,
    input  logic                       core_acc,
    input  logic [ADDR_W-DATA_W-1:0]   core_bsr,
    input  logic [DATA_W-1:0]          core_wdata,
    output logic [DATA_W-1:0]          core_rdata,
    output logic [ADDR_W-1:0]          ram_addr,
    output logic                       ram_we,
    output logic [DATA_W-1:0]          ram_wdata,
    input  logic [DATA_W-1:0]          ram_rdata
);
    localparam int BANK_W = ADDR_W - DATA_W;
    localparam int IDX_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1;

    typedef struct packed {
        tgt_e              kind;
        logic [ADDR_W-1:0] addr;
        logic [IDX_W-1:0]  idx;
        logic              hi;
    } route_t;

    logic [ADDR_W-1:0]         dir_addr;
    logic [ADDR_W-1:0]         ind_addr;
    logic [NUM_PTR*ADDR_W-1:0] ptr_flat;

    logic             a_is_ptr, a_hi, a_is_virt;
    logic [IDX_W-1:0] a_pidx, a_vidx;
    logic             b_is_ptr, b_hi, b_is_virt;
    logic [IDX_W-1:0] b_pidx, b_vidx;

    route_t            route;
    logic [ADDR_W-1:0] sel_ptr;
    logic [DATA_W-1:0] ptr_byte;

    ptr_direct_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_direct (
        .op   (core_op),
        .acc  (core_acc),
        .bsr  (core_bsr),
        .addr (dir_addr)
    );

    ptr_sfr_decode #(
        .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W),
        .PTR_BASE(PTR_BASE), .VIRT_BASE(VIRT_BASE)
    ) u_dec_dir (
        .addr     (dir_addr),
        .is_ptr   (a_is_ptr),
        .ptr_idx  (a_pidx),
        .ptr_hi   (a_hi),
        .is_virt  (a_is_virt),
        .virt_idx (a_vidx)
    );

    // Pointer picked by the indirect operand named in the direct address
    always_comb begin
        ind_addr = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (a_vidx == IDX_W'(i)) begin
                ind_addr = ptr_flat[i*ADDR_W +: ADDR_W];
            end
        end
    end

    ptr_sfr_decode #(
        .ADDR_W(ADDR_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W),
        .PTR_BASE(PTR_BASE), .VIRT_BASE(VIRT_BASE)
    ) u_dec_ind (
        .addr     (ind_addr),
        .is_ptr   (b_is_ptr),
        .ptr_idx  (b_pidx),
        .ptr_hi   (b_hi),
        .is_virt  (b_is_virt),
        .virt_idx (b_vidx)
    );

    // Final target: direct path, or one level of indirection
    always_comb begin
        route.addr = a_is_virt ? ind_addr : dir_addr;
        route.idx  = a_is_virt ? b_pidx : a_pidx;
        route.hi   = a_is_virt ? b_hi : a_hi;
        if (a_is_virt && b_is_virt) begin
            route.kind = TGT_NULL;
        end else if (a_is_virt ? b_is_ptr : a_is_ptr) begin
            route.kind = TGT_PTR;
        end else if (a_is_virt) begin
            route.kind = TGT_RAM;
        end else begin
            route.kind = TGT_RAM;
        end
    end

    always_comb begin
        sel_ptr = '0;
        for (int i = 0; i < NUM_PTR; i++) begin
            if (route.idx == IDX_W'(i)) begin
                sel_ptr = ptr_flat[i*ADDR_W +: ADDR_W];
            end
        end
        if (route.hi) begin
            ptr_byte = {{(DATA_W-BANK_W){1'b0}}, sel_ptr[ADDR_W-1:DATA_W]};
        end else begin
            ptr_byte = sel_ptr[DATA_W-1:0];
        end
    end

    ptr_file #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR), .IDX_W(IDX_W)
    ) u_ptrs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (core_wr && (route.kind == TGT_PTR)),
        .wr_idx   (route.idx),
        .wr_hi    (route.hi),
        .wr_data  (core_wdata),
        .ptr_flat (ptr_flat)
    );

    always_comb begin
        ram_addr  = route.addr;
        ram_we    = core_wr && (route.kind == TGT_RAM);
        ram_wdata = core_wdata;
        if (!core_rd) begin
            core_rdata = '0;
        end else begin
            unique case (route.kind)
                TGT_RAM: core_rdata = ram_rdata;
                TGT_PTR: core_rdata = ptr_byte;
                default: core_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/ptr_addr_chk.sv
module ptr_addr_chk #(
    parameter int                 ADDR_W    = 12,
    parameter int                 DATA_W    = 8,
    parameter int                 NUM_PTR   = 3,
    parameter logic [ADDR_W-1:0]  PTR_BASE  = 12'hFD0,
    parameter logic [ADDR_W-1:0]  VIRT_BASE = 12'hFD8
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      core_rd,
    input logic                      core_wr,
    input logic [DATA_W-1:0]         core_op,
    input logic                      core_acc,
    input logic [DATA_W-1:0]         core_rdata,
    input logic [ADDR_W-1:0]         ram_addr,
    input logic                      ram_we,
    input logic [NUM_PTR*ADDR_W-1:0] ptr_flat
);
    localparam int BANK_W = ADDR_W - DATA_W;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (ptr_flat == '0)); // R1

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !core_wr |=> $stable(ptr_flat)); // R9

    AST_WE_NEEDS_WR: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> core_wr); // R10

    AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
        !core_rd |-> (core_rdata == '0)); // R11

    for (genvar g = 0; g < NUM_PTR; g++) begin : g_chk
        logic [ADDR_W-1:0] p;
        logic              p_virt;
        logic              p_sfr;
        assign p      = ptr_flat[g*ADDR_W +: ADDR_W];
        assign p_virt = (p >= VIRT_BASE) && (p < VIRT_BASE + ADDR_W'(NUM_PTR));
        assign p_sfr  = p_virt ||
                        ((p >= PTR_BASE) && (p < PTR_BASE + ADDR_W'(2 * NUM_PTR)));

        AST_HI_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (rst)
            (core_rd && core_acc &&
             core_op == PTR_BASE[DATA_W-1:0] + DATA_W'(2 * g + 1))
            |-> (core_rdata[DATA_W-1:BANK_W] == '0)); // R3

        AST_PTR_NO_RAM_WE: assert property (@(posedge clk) disable iff (rst)
            (core_wr && core_acc &&
             (core_op == PTR_BASE[DATA_W-1:0] + DATA_W'(2 * g) ||
              core_op == PTR_BASE[DATA_W-1:0] + DATA_W'(2 * g + 1)))
            |-> !ram_we); // R2

        AST_VIRT_FOLLOWS_PTR: assert property (@(posedge clk) disable iff (rst)
            (core_acc && core_op == VIRT_BASE[DATA_W-1:0] + DATA_W'(g) && !p_sfr)
            |-> (ram_addr == p)); // R6

        AST_RECURSION_BLOCKED: assert property (@(posedge clk) disable iff (rst)
            (core_acc && core_op == VIRT_BASE[DATA_W-1:0] + DATA_W'(g) && p_virt)
            |-> (!ram_we && core_rdata == '0)); // R8
    end
endmodule

bind ptr_addr_unit ptr_addr_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_PTR(NUM_PTR),
    .PTR_BASE(PTR_BASE), .VIRT_BASE(VIRT_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_rd    (core_rd),
    .core_wr    (core_wr),
    .core_op    (core_op),
    .core_acc   (core_acc),
    .core_rdata (core_rdata),
    .ram_addr   (ram_addr),
    .ram_we     (ram_we),
    .ptr_flat   (ptr_flat)
);

// File: tb/test_ptr_addr_unit.sv
module test_ptr_addr_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        core_rd = 1'b0, core_wr = 1'b0, core_acc = 1'b0;
    logic [7:0]  core_op = '0, core_wdata = '0;
    logic [3:0]  core_bsr = '0;
    logic [7:0]  core_rdata, ram_wdata, ram_rdata;
    logic [11:0] ram_addr;
    logic        ram_we;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;
    logic [11:0] ptr_m [3];

    always #10 clk = ~clk;

    // RAM model: contents are a fixed function of the address
    function automatic logic [7:0] mem_of(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]};
    endfunction
    assign ram_rdata = mem_of(ram_addr);

    ptr_addr_unit i_ptr_addr_unit (
        .clk(clk), .rst(rst), .core_rd(core_rd), .core_wr(core_wr),
        .core_op(core_op), .core_acc(core_acc), .core_bsr(core_bsr),
        .core_wdata(core_wdata), .core_rdata(core_rdata),
        .ram_addr(ram_addr), .ram_we(ram_we), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] dir_of(input logic [7:0] op, input logic acc,
                                           input logic [3:0] bsr);
        if (!acc) return {bsr, op};
        return op[7] ? {4'hF, op} : {4'h0, op};
    endfunction

    // kind: 0 RAM, 1 pointer byte, 2 indirect operand
    function automatic int kind_of(input logic [11:0] a, output int idx, output bit hi);
        idx = 0; hi = 0;
        if (a >= 12'hFD0 && a <= 12'hFD5) begin
            idx = int'(a - 12'hFD0) / 2; hi = a[0]; return 1;
        end
        if (a >= 12'hFD8 && a <= 12'hFDA) begin
            idx = int'(a - 12'hFD8); return 2;
        end
        return 0;
    endfunction

    task automatic access(input logic rd, input logic wr, input logic [7:0] op,
                          input logic acc, input logic [3:0] bsr,
                          input logic [7:0] wd, input string tag);
        logic [11:0] a;
        int k, idx, k2, idx2;
        bit hi, hi2, via;
        string t;
        @(negedge clk);
        core_rd = rd; core_wr = wr; core_op = op; core_acc = acc;
        core_bsr = bsr; core_wdata = wd;
        #1;
        a = dir_of(op, acc, bsr);
        k = kind_of(a, idx, hi);
        via = (k == 2);
        if (via) begin
            a = ptr_m[idx];
            k2 = kind_of(a, idx2, hi2);
            k = (k2 == 2) ? 3 : k2;
            idx = idx2; hi = hi2;
        end
        if (tag != "") t = tag;
        else if (k == 3) t = "R8";
        else if (k == 1) t = via ? "R12" : (hi ? "R3" : "R2");
        else if (via) t = "R6";
        else t = acc ? "R5" : "R4";
        if (k == 0) begin
            chk(t, ram_addr, a);
            chk("R10", ram_we, wr);
            if (wr) chk("R10", ram_wdata, wd);
            if (rd) chk(t, core_rdata, mem_of(a));
        end else begin
            chk((k == 3) ? "R8" : "R10", ram_we, 1'b0);
            if (rd) chk(t, core_rdata,
                        (k == 3) ? 8'h00 : (hi ? {4'h0, ptr_m[idx][11:8]} : ptr_m[idx][7:0]));
        end
        if (!rd) chk("R11", core_rdata, 8'h00);
        if (wr && k == 1) begin
            if (hi) ptr_m[idx][11:8] = wd[3:0];
            else ptr_m[idx][7:0] = wd;
        end
    endtask

    task automatic set_ptr(input int n, input logic [11:0] v);
        access(1'b0, 1'b1, 8'hD1 + 8'(2 * n), 1'b1, 4'h0, {4'hA, v[11:8]}, "R2");
        access(1'b0, 1'b1, 8'hD0 + 8'(2 * n), 1'b1, 4'h0, v[7:0], "R2");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        for (int i = 0; i < 3; i++) ptr_m[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        // R1: every pointer byte reads zero after reset
        for (int i = 0; i < 6; i++) access(1'b1, 1'b0, 8'hD0 + 8'(i), 1'b1, 4'h0, 8'h00, "R1");
        // R3: upper nibble of the high byte dropped
        access(1'b0, 1'b1, 8'hD3, 1'b1, 4'h0, 8'hFE, "R3");
        access(1'b1, 1'b0, 8'hD3, 1'b1, 4'h0, 8'h00, "R3");
        // R9: low byte written, used through operand 1 in the very next cycle
        access(1'b0, 1'b1, 8'hD2, 1'b1, 4'h0, 8'hCC, "R9");
        access(1'b1, 1'b0, 8'hD9, 1'b1, 4'h0, 8'h00, "R9");
        // R7: bank number has no effect on an indirect access
        for (int b = 0; b < 16; b++) access(1'b1, 1'b0, 8'hD9, 1'b1, 4'(b), 8'h00, "R7");
        access(1'b1, 1'b0, 8'hD9, 1'b0, 4'hF, 8'h00, "R7");
        // R6: read-modify-write through operand 1 at ECCh
        v = mem_of(12'hECC) + 8'h05;
        access(1'b1, 1'b0, 8'hD9, 1'b1, 4'h3, 8'h00, "R6");
        access(1'b0, 1'b1, 8'hD9, 1'b1, 4'h3, v, "R6");
        // R4 / R5 direct mapping corners
        access(1'b1, 1'b0, 8'h33, 1'b0, 4'h5, 8'h00, "R4");
        access(1'b1, 1'b1, 8'hFF, 1'b0, 4'h0, 8'h12, "R4");
        access(1'b1, 1'b0, 8'h7F, 1'b1, 4'h9, 8'h00, "R5");
        access(1'b0, 1'b1, 8'h80, 1'b1, 4'h9, 8'h44, "R5");
        // R8: pointer aimed at an indirect operand
        set_ptr(2, 12'hFDA);
        access(1'b1, 1'b1, 8'hDA, 1'b1, 4'h0, 8'h77, "R8");
        set_ptr(2, 12'hFD8);
        access(1'b1, 1'b1, 8'hDA, 1'b1, 4'h0, 8'h77, "R8");
        access(1'b1, 1'b0, 8'hD4, 1'b1, 4'h0, 8'h00, "R8");
        // R12: pointer 0 aimed at pointer 1 high byte
        set_ptr(0, 12'hFD3);
        access(1'b0, 1'b1, 8'hD8, 1'b1, 4'h0, 8'h07, "R12");
        access(1'b1, 1'b0, 8'hD3, 1'b1, 4'h0, 8'h00, "R12");
        access(1'b1, 1'b0, 8'hD8, 1'b0, 4'hF, 8'h00, "R12");
        // R11: idle cycle
        access(1'b0, 1'b0, 8'hD9, 1'b1, 4'h0, 8'h00, "R11");
        // Random mix weighted toward the special-register region
        void'($urandom(32'h5eed_1234));
        for (int i = 0; i < 1500; i++) begin
            logic [31:0] r;
            logic [7:0] op;
            r = $urandom;
            op = (r[1:0] == 2'd0) ? $urandom : 8'hD0 + 8'($urandom_range(0, 11));
            access(r[2], r[3], op, r[4] | r[5], 4'($urandom), 8'($urandom), "");
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule